// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

The block steers 64 device request lines to up to four processors. One shared raw vector holds a bit for every source that is currently requesting. Each processor owns a 64-bit enable mask, and from it a 64-bit pending vector that is always the AND of that mask with the raw vector. Each processor receives one level-sensitive interrupt line, which is the OR of its pending vector, registered once.

Device logic raises or drops one request line per cycle through a source port. Software reaches the masks, the pending vectors and the raw vector over a simple register bus. A mask write that enables a source which is already requesting asserts the processor's line. A mask write that disables a delivering source withdraws it. The bus side is a three-state machine. `ST_IDLE` accepts a request. A legal access moves it to `ST_DONE` and an illegal one to `ST_FAULT`. Both of these return to `ST_IDLE` on the next cycle.

Top module: `dev_irq_router`

## Requirements
- R1: After reset all masks, the raw vector and all pending vectors read as zero, `cpu_irq` is low and no response is pending.
- R2: A source event with `src_set`=1 sets raw bit `src_idx` at the clock edge that accepts it.
- R3: The pending vector of each CPU always equals that CPU's mask AND the raw vector, after mask writes and after source events alike.
- R4: A mask write that enables a source whose raw bit is already set makes that CPU's pending bit and `cpu_irq` line assert.
- R5: A mask write that clears a bit which was delivering an interrupt removes it from pending; with no other pending bit the CPU's `cpu_irq` line drops.
- R6: A source event with `src_set`=0 clears the raw bit and its pending bits; clearing a raw bit that is already zero changes no state.
- R7: `cpu_irq[c]` equals the OR of CPU c's pending vector as it was one cycle earlier.
- R8: The register index is `req_addr >> 6`. Index c (0..NUM_CPU-1) is the mask of CPU c, index NUM_CPU+c is the pending vector of CPU c, and index 2*NUM_CPU is the raw vector. Any other index, or nonzero `req_addr[5:0]`, is an error.
- R9: A narrow read (`req_wide`=0) of the raw vector is legal and returns its low 32 bits, zero-extended.
- R10: Any other narrow access (a narrow read of a mask or pending vector, or any narrow write) is an error and changes no state.
- R11: A write to a pending vector, to the raw vector or to an unmapped index is an error and leaves every mask unchanged.
- R12: The response comes in the cycle after acceptance: `rsp_valid` is high for exactly one cycle, `rsp_err` pulses with it on an error, and `req_ready` is low while the response is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Source event this cycle |
| src_set | input | 1 | 1 raises the line, 0 drops it |
| src_idx | input | 6 | Source line number |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Bus machine is idle and accepts a request |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | 1 for a 64-bit access, 0 for a 32-bit access |
| req_addr | input | 12 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Access was illegal |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| cpu_irq | output | 4 | Device interrupt level per CPU |

## Verification
The bench attacks the two orderings of mask and request. It enables a mask after the source is already raised, and raises a source under an enabled mask. A router that recomputed pending only on source events would miss the first case and leave `cpu_irq` low. It also disables a mask while that source is delivering. A design that only ever set pending bits would keep the line high. It clears a line that was never raised and a source at bit 50, which lies above the narrow-read window. The bench then reads the raw vector at both widths, which exposes a toggling clear or a narrow read that leaks upper bits. Every class of illegal access is followed by a read-back of the masks. A design that half-applied an erroring write would show a changed mask.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int OFFSET_BITS = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DONE,
        ST_FAULT
    } bus_state_e;

    typedef enum logic [1:0] {
        RK_MASK,
        RK_PEND,
        RK_RAW,
        RK_NONE
    } reg_kind_e;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int IDX_W  = ADDR_W - OFFSET_BITS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              write,
    input  logic              wide,
    output reg_kind_e         kind,
    output logic [CPU_W-1:0]  cpu,
    output logic              legal
);
    logic [IDX_W-1:0] idx;
    logic             aligned;

    assign idx     = addr[ADDR_W-1:OFFSET_BITS];
    assign aligned = (addr[OFFSET_BITS-1:0] == '0);

    always_comb begin
        kind = RK_NONE;
        cpu  = '0;
        if (int'(idx) < NUM_CPU) begin
            kind = RK_MASK;
            cpu  = CPU_W'(idx);
        end else if (int'(idx) < 2 * NUM_CPU) begin
            kind = RK_PEND;
            cpu  = CPU_W'(idx - IDX_W'(NUM_CPU));
        end else if (int'(idx) == 2 * NUM_CPU) begin
            kind = RK_RAW;
        end
    end

    always_comb begin
        if (kind == RK_NONE || !aligned)
            legal = 1'b0;
        else if (write)
            legal = wide && (kind == RK_MASK);
        else
            legal = wide || (kind == RK_RAW);
    end
endmodule

// File: rtl/irq_raw_vector.sv
module irq_raw_vector #(
    parameter int NUM_SRC = 64,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_valid,
    input  logic               src_set,
    input  logic [SRC_W-1:0]   src_idx,
    output logic [NUM_SRC-1:0] raw_nxt,
    output logic [NUM_SRC-1:0] raw_q
);
    always_comb begin
        raw_nxt = raw_q;
        if (src_valid)
            raw_nxt[src_idx] = src_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            raw_q <= '0;
        else
            raw_q <= raw_nxt;
    end
endmodule

// File: rtl/irq_cpu_lane.sv
module irq_cpu_lane #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic [NUM_SRC-1:0] raw_nxt,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               irq_q
);
    logic [NUM_SRC-1:0] mask_nxt;

    assign mask_nxt = mask_we ? mask_wdata : mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            mask_q <= mask_nxt;
            pend_q <= mask_nxt & raw_nxt;
            irq_q  <= |pend_q;
        end
    end
endmodule

// File: rtl/dev_irq_router.sv
module dev_irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    localparam int SRC_W  = $clog2(NUM_SRC),
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int HALF_W = NUM_SRC / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_valid,
    input  logic               src_set,
    input  logic [SRC_W-1:0]   src_idx,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic               req_wide,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [NUM_SRC-1:0] req_wdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [NUM_SRC-1:0] rsp_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);
    bus_state_e state_q, state_d;
    reg_kind_e  kind;
    logic [CPU_W-1:0] cpu_sel;
    logic       legal;
    logic       accept;

    logic [NUM_SRC-1:0] raw_nxt, raw_q;
    logic [NUM_SRC-1:0] mask_arr [NUM_CPU];
    logic [NUM_SRC-1:0] pend_arr [NUM_CPU];
    logic [NUM_CPU*NUM_SRC-1:0] mask_flat, pend_flat;
    logic [NUM_SRC-1:0] rd_mux, rdata_q;

    irq_reg_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
        .addr  (req_addr),
        .write (req_write),
        .wide  (req_wide),
        .kind  (kind),
        .cpu   (cpu_sel),
        .legal (legal)
    );

    irq_raw_vector #(.NUM_SRC(NUM_SRC)) u_raw (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .src_set   (src_set),
        .src_idx   (src_idx),
        .raw_nxt   (raw_nxt),
        .raw_q     (raw_q)
    );

    assign accept = req_valid && req_ready;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_lane
        logic we;
        assign we = accept && legal && req_write && (kind == RK_MASK)
                    && (int'(cpu_sel) == c);
        irq_cpu_lane #(.NUM_SRC(NUM_SRC)) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_we    (we),
            .mask_wdata (req_wdata),
            .raw_nxt    (raw_nxt),
            .mask_q     (mask_arr[c]),
            .pend_q     (pend_arr[c]),
            .irq_q      (cpu_irq[c])
        );
        assign mask_flat[c*NUM_SRC +: NUM_SRC] = mask_arr[c];
        assign pend_flat[c*NUM_SRC +: NUM_SRC] = pend_arr[c];
    end

    // Read selection
    always_comb begin
        unique case (kind)
            RK_MASK: rd_mux = mask_arr[cpu_sel];
            RK_PEND: rd_mux = pend_arr[cpu_sel];
            RK_RAW:  rd_mux = req_wide ? raw_q
                                       : {{(NUM_SRC-HALF_W){1'b0}}, raw_q[HALF_W-1:0]};
            default: rd_mux = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = legal ? ST_DONE : ST_FAULT;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (accept)
            rdata_q <= (legal && !req_write) ? rd_mux : '0;
    end

    // Outputs
    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q != ST_IDLE);
        rsp_err   = (state_q == ST_FAULT);
        rsp_rdata = rdata_q;
    end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_SRC = 64,
    parameter int NUM_CPU = 4,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       src_valid,
    input logic                       src_set,
    input logic [SRC_W-1:0]           src_idx,
    input logic [NUM_SRC-1:0]         raw_q,
    input logic [NUM_CPU*NUM_SRC-1:0] mask_flat,
    input logic [NUM_CPU*NUM_SRC-1:0] pend_flat,
    input logic [NUM_CPU-1:0]         cpu_irq,
    input logic                       req_ready,
    input logic                       rsp_valid,
    input logic                       rsp_err
);
    logic [NUM_CPU-1:0] pend_any;
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++)
            pend_any[c] = |pend_flat[c*NUM_SRC +: NUM_SRC];
    end

    // R3
    pend_matches_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_flat == (mask_flat & {NUM_CPU{raw_q}}));

    // R7
    irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == $past(pend_any));

    // R2
    src_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && src_set) |=> raw_q[$past(src_idx)]);

    // R6
    spurious_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_valid && !src_set && !raw_q[src_idx]) |=> $stable(raw_q));

    // R12
    err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> !rsp_err);

    // R12
    rsp_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R11
    fault_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> $stable(mask_flat));
endmodule

bind dev_irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_set   (src_set),
    .src_idx   (src_idx),
    .raw_q     (raw_q),
    .mask_flat (mask_flat),
    .pend_flat (pend_flat),
    .cpu_irq   (cpu_irq),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err)
);

// File: tb/dev_irq_router_tb.sv
module dev_irq_router_tb;
    localparam int NS = 64;
    localparam int NC = 4;

    logic clk = 0;
    logic rst_n = 0;
    logic src_valid = 0, src_set = 0;
    logic [5:0] src_idx = '0;
    logic req_valid = 0, req_write = 0, req_wide = 1;
    logic [11:0] req_addr = '0;
    logic [NS-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err;
    logic [NS-1:0] rsp_rdata;
    logic [NC-1:0] cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct packed {
        logic          err;
        logic [NS-1:0] data;
        logic [7:0]    req;
    } exp_t;
    exp_t sb_q[$];

    logic [NS-1:0] m_mask [NC];
    logic [NS-1:0] m_raw;

    always #10 clk = ~clk;

    dev_irq_router u_dut (
        .clk(clk), .rst_n(rst_n),
        .src_valid(src_valid), .src_set(src_set), .src_idx(src_idx),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cpu_irq(cpu_irq)
    );

    task automatic check(input bit ok, input int req, input logic [NS-1:0] act,
                         input logic [NS-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard as responses appear (R12 timing)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(0, 12, rsp_rdata, '0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(rsp_err == e.err, int'(e.req), NS'(rsp_err), NS'(e.err));
                check(rsp_rdata == e.data, int'(e.req), rsp_rdata, e.data);
                // R12: bus not ready while response shown
                check(req_ready == 1'b0, 12, NS'(req_ready), '0);
            end
        end
    end

    // Driver: model computes expected response, pushes, drives one access
    task automatic bus(input bit wr, input bit wide, input logic [11:0] addr,
                       input logic [NS-1:0] wd, input int req);
        exp_t e;
        int idx;
        bit legal;
        logic [NS-1:0] rd;
        idx = int'(addr >> 6);
        rd = '0;
        legal = (addr[5:0] == 0) && (idx <= 2*NC);
        if (legal) begin
            if (wr) legal = wide && (idx < NC);
            else    legal = wide || (idx == 2*NC);
        end
        if (legal && !wr) begin
            if (idx < NC)        rd = m_mask[idx];
            else if (idx < 2*NC) rd = m_mask[idx-NC] & m_raw;
            else                 rd = wide ? m_raw : {32'b0, m_raw[31:0]};
        end
        if (legal && wr) m_mask[idx] = wd;
        e.err = !legal; e.data = rd; e.req = 8'(req);
        sb_q.push_back(e);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_wide = wide; req_addr = addr; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic src(input bit set, input int idx);
        @(negedge clk);
        src_valid = 1; src_set = set; src_idx = 6'(idx);
        m_raw[idx] = set;
        @(posedge clk);
        @(negedge clk);
        src_valid = 0;
    endtask

    task automatic chk_irq(input int req);
        logic [NC-1:0] exp;
        @(negedge clk);
        for (int c = 0; c < NC; c++) exp[c] = |(m_mask[c] & m_raw);
        check(cpu_irq == exp, req, NS'(cpu_irq), NS'(exp));
    endtask

    function automatic logic [11:0] a(input int idx);
        return 12'(idx << 6);
    endfunction

    initial begin
        for (int c = 0; c < NC; c++) m_mask[c] = '0;
        m_raw = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check(cpu_irq == 0 && !rsp_valid && req_ready, 1, NS'(cpu_irq), '0);
        bus(0, 1, a(0), '0, 1);
        bus(0, 1, a(NC), '0, 1);
        bus(0, 1, a(2*NC), '0, 1);
        // R8 mask map and read back
        bus(1, 1, a(0), (64'd1 << 5) | (64'd1 << 63), 8);
        bus(1, 1, a(1), 64'd1 << 5, 8);
        bus(1, 1, a(2), 64'd1 << 10, 8);
        bus(0, 1, a(0), '0, 8);
        bus(0, 1, a(2), '0, 8);
        chk_irq(1);
        // R2 / R7 source raised under enabled masks
        src(1, 5);
        chk_irq(7);
        bus(0, 1, a(2*NC), '0, 2);
        // R3 pending readback
        bus(0, 1, a(NC+0), '0, 3);
        bus(0, 1, a(NC+1), '0, 3);
        bus(0, 1, a(NC+2), '0, 3);
        src(1, 10);
        chk_irq(3);
        // R4 raise first, enable afterwards
        src(1, 40);
        chk_irq(4);
        bus(1, 1, a(3), 64'd1 << 40, 4);
        chk_irq(4);
        bus(0, 1, a(NC+3), '0, 4);
        // R5 disable a delivering mask bit
        bus(1, 1, a(0), 64'd1 << 63, 5);
        chk_irq(5);
        bus(0, 1, a(NC+0), '0, 5);
        // R6 real clear then spurious clear
        src(0, 5);
        chk_irq(6);
        bus(0, 1, a(2*NC), '0, 6);
        src(0, 7);
        chk_irq(6);
        bus(0, 1, a(2*NC), '0, 6);
        // R9 narrow raw read hides upper half
        src(1, 50);
        bus(0, 0, a(2*NC), '0, 9);
        bus(0, 1, a(2*NC), '0, 9);
        // R10 other narrow accesses
        bus(1, 0, a(1), '1, 10);
        bus(0, 0, a(1), '0, 10);
        bus(0, 0, a(NC+1), '0, 10);
        bus(0, 1, a(1), '0, 10);
        // R11 writes to read-only or unmapped
        bus(1, 1, a(NC+0), '1, 11);
        bus(1, 1, a(2*NC), '1, 11);
        bus(1, 1, a(2*NC+1), '1, 11);
        bus(0, 1, a(2*NC+3), '0, 11);
        // R8 misaligned offset
        bus(1, 1, a(2) | 12'h008, '1, 8);
        bus(0, 1, a(2), '0, 11);
        bus(0, 1, a(3), '0, 11);
        chk_irq(11);
        repeat (3) @(negedge clk);
        // R12 every pushed response was seen
        check(sb_q.size() == 0, 12, NS'(sb_q.size()), '0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R12 watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule